// File: doc/BRIEF.md
# Serial NOR Flash Command Guard

This block sits behind the serial pins of a small NOR flash slave. It turns the serial bit stream into an opcode and an optional parameter byte, keeps the status byte, and decides whether a command that changes the array or the status byte is allowed to run. The serial clock is not used as a clock here. Each rising serial clock edge arrives as a one-cycle strobe `sck`, already synchronised to `clk`.

A command takes effect only when chip select is released. Program, sector erase and bulk erase that pass every gate are handed to an array model through a request/grant pair. The model then reports `mem_busy` for as long as the operation lasts. A status write is timed inside the block. The protection bits stay in storage that reset does not clear. A low-power lockout state lets the block ignore all traffic except the wake command.

Top module: `nor_wp_ctrl`

## Requirements
- R1: `sr_out` carries the lock bit at bit 7, the block-protect pair at bits 3:2, the write-enable flag at bit 1 and busy at bit 0. Bits 6:4 read 0. After `rst`, the write-enable flag and busy are 0.
- R2: A frame is decoded when `cs_n` rises, and only if it holds at least 8 counted bits and its bit count is a multiple of 8. Bits are sent MSB first and the first byte is the opcode. Any other frame is discarded.
- R3: Opcode 06h sets the write-enable flag. Opcode 04h clears it.
- R4: Opcodes 02h (program), D8h (sector erase), C7h (bulk erase) and 01h (status write) are discarded while the write-enable flag is 0.
- R5: With the protect pair at 11, program, sector erase and bulk erase are all rejected. At 10 or 01, program and sector erase are accepted and bulk erase is rejected. At 00, all three are accepted.
- R6: Opcode 01h needs a second byte, so the frame must carry at least 16 bits. It holds busy for WSR_CYCLES cycles and then copies byte bit 7 to the lock bit and byte bits 3:2 to the protect pair. It then clears the write-enable flag. The command is rejected when the lock bit is 1 and `wp_n` is 0.
- R7: An accepted array command raises `mem_req` with `mem_op` (0 program, 1 sector erase, 2 bulk erase) until `mem_gnt`. Busy then stays high until `mem_busy` falls, and the write-enable flag clears at that point.
- R8: While busy is 1, every command is ignored.
- R9: While `hold_n` is 0, `sck` strobes are ignored and the partial bit count is kept. Hold does not stop an operation that is already running.
- R10: Opcode B9h sets `dpd_o`. While `dpd_o` is 1, every opcode except ABh is ignored. ABh clears `dpd_o`.
- R11: The lock bit and the protect pair keep their values through `rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | One-cycle strobe per serial clock rise |
| mosi | input | 1 | Serial data in |
| hold_n | input | 1 | Pause of serial shifting, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| mem_gnt | input | 1 | Array model accepts the request |
| mem_busy | input | 1 | Array operation in progress |
| mem_req | output | 1 | Array operation request |
| mem_op | output | 2 | Array operation code |
| sr_out | output | 8 | Status byte |
| dpd_o | output | 1 | Low-power lockout active |

## Verification
A wrong bit count or a misplaced byte capture changes whether busy or the write-enable flag moves in the first cycle after `cs_n` rises, so such a fault shows at the port at once. A wrong protection decision appears in that same cycle as busy rising when it should not, or staying low when it should rise. A sequencer that never ends keeps busy high until the bench's wait limit runs out. Corrupted protection storage shows in bits 7 and 3:2 after the next status write completes or after a reset.

// File: rtl/nwp_pkg.sv
package nwp_pkg;
    localparam logic [7:0] OPC_WREN = 8'h06;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_PP   = 8'h02;
    localparam logic [7:0] OPC_SE   = 8'hD8;
    localparam logic [7:0] OPC_BE   = 8'hC7;
    localparam logic [7:0] OPC_DPD  = 8'hB9;
    localparam logic [7:0] OPC_RES  = 8'hAB;

    typedef enum logic [1:0] {
        MOP_PP = 2'd0,
        MOP_SE = 2'd1,
        MOP_BE = 2'd2
    } mem_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_EXEC,
        ST_WSR
    } seq_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] bp;
    } nv_t;

    // array command allowed under a block-protect setting
    function automatic logic area_ok(input logic [1:0] bp, input mem_op_e op);
        if (op == MOP_BE) return (bp == 2'b00);
        return (bp != 2'b11);
    endfunction
endpackage

// File: rtl/nwp_shift.sv
module nwp_shift
    import nwp_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          sck,
    input  logic          mosi,
    input  logic          hold_n,
    output logic          frame_end,
    output logic          aligned,
    output logic [BW-1:0] opcode,
    output logic [1:0]    nbytes,
    output nv_t           new_nv
);
    localparam int CW = $clog2(BW);

    logic [BW-2:0] shreg;
    logic [CW-1:0] bitcnt;
    logic          cs_q;
    logic [BW-1:0] byte_nx;

    assign byte_nx   = {shreg, mosi};
    assign frame_end = cs_n && !cs_q;
    assign aligned   = (bitcnt == '0) && (nbytes != 2'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            shreg  <= '0;
            bitcnt <= '0;
            nbytes <= 2'd0;
            opcode <= '0;
            new_nv <= '0;
        end else begin
            cs_q <= cs_n;
            if (cs_n) begin
                bitcnt <= '0;
                nbytes <= 2'd0;
            end else if (sck && hold_n) begin
                shreg  <= byte_nx[BW-2:0];
                bitcnt <= bitcnt + 1'b1;
                if (bitcnt == CW'(BW-1)) begin
                    if (nbytes == 2'd0) opcode <= byte_nx;
                    if (nbytes == 2'd1) new_nv <= '{lock: byte_nx[7], bp: byte_nx[3:2]};
                    if (nbytes != 2'd2) nbytes <= nbytes + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/nwp_gate.sv
module nwp_gate
    import nwp_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [1:0] nbytes,
    input  logic       wel,
    input  nv_t        nv,
    input  logic       wp_n,
    output logic       go_wsr,
    output logic       go_mem,
    output mem_op_e    mop
);
    logic is_mem;

    always_comb begin
        is_mem = 1'b1;
        mop    = MOP_PP;
        unique case (opcode)
            OPC_PP:  mop = MOP_PP;
            OPC_SE:  mop = MOP_SE;
            OPC_BE:  mop = MOP_BE;
            default: is_mem = 1'b0;
        endcase
        go_mem = is_mem && wel && area_ok(nv.bp, mop);
        go_wsr = (opcode == OPC_WRSR) && wel && (nbytes == 2'd2)
                 && !(nv.lock && !wp_n);
    end
endmodule

// File: rtl/nwp_ctrl.sv
module nwp_ctrl
    import nwp_pkg::*;
#(
    parameter int WSR_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_end,
    input  logic       aligned,
    input  logic [7:0] opcode,
    input  nv_t        new_nv,
    input  logic       go_wsr,
    input  logic       go_mem,
    input  mem_op_e    mop,
    input  logic       mem_gnt,
    input  logic       mem_busy,
    output logic       mem_req,
    output mem_op_e    mem_op,
    output logic       wel,
    output logic       busy,
    output logic       dpd,
    output nv_t        nv
);
    localparam int TW = $clog2(WSR_CYCLES + 1);

    seq_e          state;
    logic [TW-1:0] tmr;
    nv_t           pend;
    nv_t           nv_q = '0;
    logic          nv_wr;

    assign nv      = nv_q;
    assign busy    = (state != ST_IDLE);
    assign mem_req = (state == ST_REQ);
    assign nv_wr   = (state == ST_WSR) && (tmr == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            wel    <= 1'b0;
            dpd    <= 1'b0;
            tmr    <= '0;
            pend   <= '0;
            mem_op <= MOP_PP;
        end else begin
            unique case (state)
                ST_IDLE: if (frame_end && aligned) begin
                    if (dpd) begin
                        if (opcode == OPC_RES) dpd <= 1'b0;
                    end else if (opcode == OPC_WREN) begin
                        wel <= 1'b1;
                    end else if (opcode == OPC_WRDI) begin
                        wel <= 1'b0;
                    end else if (opcode == OPC_DPD) begin
                        dpd <= 1'b1;
                    end else if (go_wsr) begin
                        state <= ST_WSR;
                        tmr   <= TW'(WSR_CYCLES - 1);
                        pend  <= new_nv;
                    end else if (go_mem) begin
                        state  <= ST_REQ;
                        mem_op <= mop;
                    end
                end
                ST_REQ:  if (mem_gnt) state <= ST_EXEC;
                ST_EXEC: if (!mem_busy) begin
                    state <= ST_IDLE;
                    wel   <= 1'b0;
                end
                ST_WSR: begin
                    if (tmr == '0) begin
                        state <= ST_IDLE;
                        wel   <= 1'b0;
                    end else begin
                        tmr <= tmr - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // protection bits: written only by a finished status write, never by reset
    always_ff @(posedge clk) begin
        if (nv_wr) nv_q <= pend;
    end
endmodule

// File: rtl/nor_wp_ctrl.sv
module nor_wp_ctrl
    import nwp_pkg::*;
#(
    parameter int WSR_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       mosi,
    input  logic       hold_n,
    input  logic       wp_n,
    input  logic       mem_gnt,
    input  logic       mem_busy,
    output logic       mem_req,
    output logic [1:0] mem_op,
    output logic [7:0] sr_out,
    output logic       dpd_o
);
    logic       frame_end, aligned, go_wsr, go_mem, wel, busy;
    logic [7:0] opcode;
    logic [1:0] nbytes;
    nv_t        new_nv, nv;
    mem_op_e    mop, op_q;

    nwp_shift #(.BW(8)) u_shift (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .hold_n(hold_n), .frame_end(frame_end), .aligned(aligned),
        .opcode(opcode), .nbytes(nbytes), .new_nv(new_nv)
    );

    nwp_gate u_gate (
        .opcode(opcode), .nbytes(nbytes), .wel(wel), .nv(nv), .wp_n(wp_n),
        .go_wsr(go_wsr), .go_mem(go_mem), .mop(mop)
    );

    nwp_ctrl #(.WSR_CYCLES(WSR_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst), .frame_end(frame_end), .aligned(aligned),
        .opcode(opcode), .new_nv(new_nv), .go_wsr(go_wsr), .go_mem(go_mem),
        .mop(mop), .mem_gnt(mem_gnt), .mem_busy(mem_busy),
        .mem_req(mem_req), .mem_op(op_q), .wel(wel), .busy(busy),
        .dpd(dpd_o), .nv(nv)
    );

    assign mem_op = op_q;
    assign sr_out = {nv.lock, 3'b000, nv.bp, wel, busy};
endmodule

// File: rtl/nor_wp_ctrl_chk.sv
module nor_wp_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       mem_req,
    input logic [1:0] mem_op,
    input logic       busy,
    input logic       wel,
    input logic [1:0] bp,
    input logic       lock,
    input logic       dpd
);
    // R7
    req_needs_wel_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> wel);

    // R5
    bulk_unprotected_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_op == 2'd2) |-> (bp == 2'b00));

    // R5
    page_area_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_op != 2'd2) |-> (bp != 2'b11));

    // R10
    sleep_idle_chk: assert property (@(posedge clk) disable iff (rst)
        dpd |-> !busy);

    // R6
    nv_on_finish_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable({lock, bp}) |-> $fell(busy));

    // R7
    finish_clears_wel_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !wel);
endmodule

bind nor_wp_ctrl nor_wp_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_op(mem_op),
    .busy(sr_out[0]), .wel(sr_out[1]), .bp(sr_out[3:2]),
    .lock(sr_out[7]), .dpd(dpd_o)
);

// File: tb/nor_wp_ctrl_test.sv
module nor_wp_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic       mem_gnt, mem_busy, mem_req, dpd_o;
    logic [1:0] mem_op;
    logic [7:0] sr_out;
    int         checks = 0, errors = 0, cyc = 0, mcnt = 0;
    logic       mb = 1'b0;

    always #2 clk = ~clk;

    nor_wp_ctrl #(.WSR_CYCLES(4)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .mosi(mosi),
        .hold_n(hold_n), .wp_n(wp_n), .mem_gnt(mem_gnt), .mem_busy(mem_busy),
        .mem_req(mem_req), .mem_op(mem_op), .sr_out(sr_out), .dpd_o(dpd_o)
    );

    // array model: grant at once, busy for 40 cycles
    assign mem_gnt  = mem_req && !mb;
    assign mem_busy = mb;
    always @(posedge clk) begin
        if (mem_gnt) begin
            mb <= 1'b1; mcnt <= 40;
        end else if (mb) begin
            mcnt <= mcnt - 1;
            if (mcnt == 1) mb <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); mosi = b; sck = 1'b1;
        @(negedge clk); sck = 1'b0;
    endtask

    // frame of nbits from {b0,b1}, MSB first; returns at the sample point
    task automatic tx(input logic [7:0] b0, input logic [7:0] b1, input int nbits);
        logic [15:0] w;
        w = {b0, b1};
        @(negedge clk); cs_n = 1'b0;
        for (int i = 0; i < nbits; i++) send_bit(i < 16 ? w[15-i] : 1'b0);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && sr_out[0]; i++) @(negedge clk);
    endtask

    task automatic set_nv(input logic lock, input logic [1:0] bp);
        tx(8'h06, 8'h00, 8);
        tx(8'h01, {lock, 3'b000, bp, 2'b00}, 16);
        wait_idle();
    endtask

    // {bp, opcode, expected busy}
    localparam logic [10:0] VEC [12] = '{
        {2'b00, 8'h02, 1'b1}, {2'b00, 8'hD8, 1'b1}, {2'b00, 8'hC7, 1'b1},
        {2'b01, 8'h02, 1'b1}, {2'b01, 8'hD8, 1'b1}, {2'b01, 8'hC7, 1'b0},
        {2'b10, 8'h02, 1'b1}, {2'b10, 8'hD8, 1'b1}, {2'b10, 8'hC7, 1'b0},
        {2'b11, 8'h02, 1'b0}, {2'b11, 8'hD8, 1'b0}, {2'b11, 8'hC7, 1'b0}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset status", sr_out, 8'h00);
        check("R10 reset dpd", {7'b0, dpd_o}, 8'h00);

        // R5 R7 protection matrix
        for (int v = 0; v < 12; v++) begin
            set_nv(1'b0, VEC[v][10:9]);
            tx(8'h06, 8'h00, 8);
            tx(VEC[v][8:1], 8'h00, 8);
            check("R5 busy after array command", {7'b0, sr_out[0]}, {7'b0, VEC[v][0]});
            wait_idle();
            check("R7 WEL after array command", {7'b0, sr_out[1]}, {7'b0, !VEC[v][0]});
        end
        set_nv(1'b0, 2'b00);

        // R3 R4 WEL gating
        tx(8'h02, 8'h00, 8);
        check("R4 program without WEL", sr_out, 8'h00);
        tx(8'h06, 8'h00, 8);
        check("R3 WREN sets WEL", sr_out, 8'h02);
        tx(8'h04, 8'h00, 8);
        check("R3 WRDI clears WEL", sr_out, 8'h00);
        tx(8'h01, 8'h8C, 16);
        check("R4 status write without WEL", sr_out, 8'h00);

        // R2 alignment
        tx(8'h06, 8'h00, 7);
        check("R2 seven-bit WREN discarded", sr_out, 8'h00);
        tx(8'h06, 8'h00, 8);
        tx(8'h02, 8'h00, 9);
        check("R2 nine-bit program discarded", sr_out, 8'h02);
        tx(8'h02, 8'h00, 24);
        check("R2 24-bit program accepted", {7'b0, sr_out[0]}, 8'h01);

        // R8 R9 commands ignored while busy, hold does not stop the run
        tx(8'h04, 8'h00, 8);
        check("R8 WRDI ignored while busy", sr_out[1:0], 2'b11);
        tx(8'hB9, 8'h00, 8);
        check("R8 sleep ignored while busy", {7'b0, dpd_o}, 8'h00);
        hold_n = 1'b0;
        wait_idle();
        hold_n = 1'b1;
        check("R9 run finishes under hold", sr_out, 8'h00);

        // R9 hold mid-byte
        @(negedge clk); cs_n = 1'b0;
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        hold_n = 1'b0;
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        hold_n = 1'b1;
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        check("R9 WREN across hold", sr_out, 8'h02);
        tx(8'h04, 8'h00, 8);

        // R6 status write and hardware lock
        set_nv(1'b1, 2'b01);
        check("R6 status write result", sr_out, 8'h84);
        wp_n = 1'b0;
        tx(8'h06, 8'h00, 8);
        tx(8'h01, 8'h00, 16);
        check("R6 locked write rejected", sr_out, 8'h86);
        tx(8'h01, 8'h00, 8);
        check("R6 one-byte status write discarded", sr_out, 8'h86);
        wp_n = 1'b1;
        tx(8'h01, 8'h08, 16);
        check("R6 write busy", {7'b0, sr_out[0]}, 8'h01);
        wait_idle();
        check("R6 unlocked write done", sr_out, 8'h08);

        // R11 protection survives reset
        tx(8'h06, 8'h00, 8);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R11 bits kept, WEL cleared", sr_out, 8'h08);

        // R10 low-power lockout
        tx(8'hB9, 8'h00, 8);
        check("R10 sleep entered", {7'b0, dpd_o}, 8'h01);
        tx(8'h06, 8'h00, 8);
        check("R10 WREN ignored asleep", sr_out, 8'h08);
        tx(8'hAB, 8'h00, 8);
        check("R10 wake", {7'b0, dpd_o}, 8'h00);
        tx(8'h06, 8'h00, 8);
        check("R10 WREN after wake", sr_out, 8'h0A);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule